// File: doc/BRIEF.md
# Dual-Standard 4:2:2 Video Timing Formatter

This block produces the raster timing for interlaced 525-line and 625-line video and serialises 4:2:2 YCbCr samples onto an 8-bit output bus. Every clock of the 27 MHz system clock carries one byte. The byte counter's lowest bit acts as the 13.5 MHz pixel enable, so each pixel takes two bytes. A caller supplies a chroma sample on `c_in` and a luma sample on `y_in`. The block picks one of them for each active byte. The caller must alternate Cb and Cr on `c_in` from pixel to pixel, so that the bus carries Cb, Y, Cr, Y. The caller can follow the raster through `avid`.

Two output modes exist. In embedded mode, each line opens with an end-of-active-video code and closes its blanking with a start-of-active-video code. Each code is four bytes, and all timing travels in-band. In discrete mode, those code slots carry plain blanking levels, and receivers rely on the sync pins. The pins are `hsync`, `vsync`, `fid`, `vblk` and `avid`, and they are driven in both modes. Each sync pin has set and clear positions programmed as a line and a pixel. A standard select input switches between the two rasters. The switch takes effect only at a frame boundary.

Each line starts at byte 0 with the end-of-active code. Blanking follows, then the start-of-active code, then the 2×active-pixel data bytes. A frame begins with field 1, which lasts `lines/2+1` lines. Field 2 takes the remaining lines.

Top module: `vid656_fmt`

## Requirements
- R1: A line lasts 2×TOT bytes, where TOT is 858 pixels for the 525-line standard (`std_sel`=0) and 864 pixels for the 625-line standard (`std_sel`=1). Bytes 0..3 of every line form the end-of-active slot.
- R2: A frame lasts 525 or 625 lines, numbered from 0. Line 0 starts the frame. Lines below `lines/2+1` belong to field 1 (F=0), and the remaining lines belong to field 2 (F=1).
- R3: `std_sel` is sampled only on the last byte of a frame, and the new raster starts with the next line 0. After reset the 525-line raster runs until the first frame boundary.
- R4: In embedded mode (`emb_mode`=1), both code slots carry FF, 00, 00, XY. The end-of-active slot is bytes 0..3 and has H=1. The start-of-active slot is the four bytes just before the active region and has H=0. XY is {1, F, V, H, V^H, F^H, F^V, F^V^H}, with bit 7 first.
- R5: The active region starts at byte 2×(TOT−720). On a line outside vertical blanking, its even bytes carry `c_in` and its odd bytes carry `y_in`, with 00 clamped to 01 and FF clamped to FE. Every other non-code byte carries 80 on even bytes and 10 on odd bytes.
- R6: In discrete mode (`emb_mode`=0), the code slots carry the blanking levels 80/10 instead of codes.
- R7: On a pixel boundary (even byte), `hsync` goes to 1 when the pixel equals `hs_on_pix` and to 0 when it equals `hs_off_pix`. Set wins if both match. It changes at no other time.
- R8: `vsync` goes to 1 at field line `vs_on_line` and pixel `vs_on_pix`, and to 0 at field line `vs_off_line` and pixel `vs_off_pix`. The field line is the line number counted from the start of the current field.
- R9: `fid` goes to 1 at frame line `fid_odd_line` and to 0 at frame line `fid_even_line`, both at pixel `fid_pix`. It is 1 during the odd field.
- R10: `vblk` goes to 1 at field line `vb_on_line` and pixel `vb_on_pix`, and to 0 at field line `vb_off_line` and pixel `vb_off_pix`.
- R11: Field lines below `vbi_lines` are vertical-blanking lines (V=1). `avid` is 1 exactly on active-region bytes. On V=1 lines it is 1 there only when `avid_in_vbi`=1.
- R12: While reset is applied, `dout` is 00, `fid` is 1, and `hsync`, `vsync`, `vblk` and `avid` are 0. Counting starts at byte 0 of line 0 on the third clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_sel | input | 1 | 0: 525-line raster, 1: 625-line raster |
| emb_mode | input | 1 | 1: embedded timing codes, 0: discrete syncs only |
| avid_in_vbi | input | 1 | Let `avid` toggle on vertical-blanking lines |
| c_in | input | 8 | Chroma sample for the current pixel |
| y_in | input | 8 | Luma sample for the current pixel |
| hs_on_pix | input | PW | Pixel where `hsync` rises |
| hs_off_pix | input | PW | Pixel where `hsync` falls |
| vs_on_line | input | LW | Field line where `vsync` rises |
| vs_on_pix | input | PW | Pixel where `vsync` rises |
| vs_off_line | input | LW | Field line where `vsync` falls |
| vs_off_pix | input | PW | Pixel where `vsync` falls |
| fid_odd_line | input | LW | Frame line where `fid` goes to 1 |
| fid_even_line | input | LW | Frame line where `fid` goes to 0 |
| fid_pix | input | PW | Pixel of both `fid` edges |
| vb_on_line | input | LW | Field line where `vblk` rises |
| vb_on_pix | input | PW | Pixel where `vblk` rises |
| vb_off_line | input | LW | Field line where `vblk` falls |
| vb_off_pix | input | PW | Pixel where `vblk` falls |
| vbi_lines | input | LW | Number of V=1 lines at the start of each field |
| dout | output | 8 | Multiplexed byte stream |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| fid | output | 1 | Field indicator, 1 in the odd field |
| vblk | output | 1 | Vertical blanking indicator |
| avid | output | 1 | Active video indicator |

## Verification
The hardest case to reach is a standard switch. `std_sel` is ignored for most of a frame, so the bench must change it mid-frame and then keep running until the boundary, where the line length and field split must change together. The bench toggles `std_sel` early in the first frame, again in the second frame, and once more right after a reset. Its reference raster follows the same frame-boundary rule. A second hard case is an `hsync` window that wraps across the line end (set pixel above clear pixel), which is programmed in one phase. Sample values of 00 and FF are injected often to exercise the clamp.

// File: rtl/vid656_pkg.sv
package vid656_pkg;

  localparam logic [7:0] BLANK_CHROMA = 8'h80;
  localparam logic [7:0] BLANK_LUMA   = 8'h10;
  localparam logic [7:0] CODE_LEAD    = 8'hFF;
  localparam logic [7:0] CODE_ZERO    = 8'h00;

  typedef enum logic {
    STD_525 = 1'b0,
    STD_625 = 1'b1
  } line_std_e;

  // timing word: marker, field, vertical, horizontal, four protection bits
  function automatic logic [7:0] timing_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/vid656_rst_sync.sv
module vid656_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/vid656_raster.sv
module vid656_raster
  import vid656_pkg::*;
#(
  parameter int TOT_A   = 858,
  parameter int ACT_A   = 720,
  parameter int LINES_A = 525,
  parameter int TOT_B   = 864,
  parameter int ACT_B   = 720,
  parameter int LINES_B = 625,
  parameter int BW      = 11,
  parameter int LW      = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          std_sel,
  output logic [BW-1:0] bcnt,
  output logic [LW-1:0] line,
  output logic [LW-1:0] lif,
  output logic          field2,
  output logic [BW-1:0] act_start
);

  localparam logic [BW-1:0] LAST_BYTE_A = BW'(2 * TOT_A - 1);
  localparam logic [BW-1:0] LAST_BYTE_B = BW'(2 * TOT_B - 1);
  localparam logic [LW-1:0] LAST_LINE_A = LW'(LINES_A - 1);
  localparam logic [LW-1:0] LAST_LINE_B = LW'(LINES_B - 1);
  localparam logic [LW-1:0] F2_LINE_A   = LW'(LINES_A / 2 + 1);
  localparam logic [LW-1:0] F2_LINE_B   = LW'(LINES_B / 2 + 1);
  localparam logic [BW-1:0] ACT_AT_A    = BW'(2 * (TOT_A - ACT_A));
  localparam logic [BW-1:0] ACT_AT_B    = BW'(2 * (TOT_B - ACT_B));

  line_std_e     std_q, std_nxt;
  logic [BW-1:0] bcnt_q, bcnt_nxt, last_byte;
  logic [LW-1:0] line_q, line_nxt, last_line, f2_line;
  logic          eol, eof;

  always_comb begin
    last_byte = (std_q == STD_625) ? LAST_BYTE_B : LAST_BYTE_A;
    last_line = (std_q == STD_625) ? LAST_LINE_B : LAST_LINE_A;
    f2_line   = (std_q == STD_625) ? F2_LINE_B   : F2_LINE_A;
    act_start = (std_q == STD_625) ? ACT_AT_B    : ACT_AT_A;
    eol       = (bcnt_q == last_byte);
    eof       = eol && (line_q == last_line);
    bcnt_nxt  = eol ? '0 : bcnt_q + 1'b1;
    line_nxt  = line_q;
    if (eol) line_nxt = eof ? '0 : line_q + 1'b1;
    std_nxt   = eof ? line_std_e'(std_sel) : std_q;
    field2    = (line_q >= f2_line);
    lif       = field2 ? (line_q - f2_line) : line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      line_q <= '0;
      std_q  <= STD_525;
    end else begin
      bcnt_q <= bcnt_nxt;
      line_q <= line_nxt;
      std_q  <= std_nxt;
    end
  end

  assign bcnt = bcnt_q;
  assign line = line_q;

endmodule

// File: rtl/vid656_syncgen.sv
module vid656_syncgen #(
  parameter int BW = 11,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] bcnt,
  input  logic [LW-1:0] line,
  input  logic [LW-1:0] lif,
  input  logic [BW-1:0] act_start,
  input  logic          avid_in_vbi,
  input  logic [BW-2:0] hs_on_pix,
  input  logic [BW-2:0] hs_off_pix,
  input  logic [LW-1:0] vs_on_line,
  input  logic [BW-2:0] vs_on_pix,
  input  logic [LW-1:0] vs_off_line,
  input  logic [BW-2:0] vs_off_pix,
  input  logic [LW-1:0] fid_odd_line,
  input  logic [LW-1:0] fid_even_line,
  input  logic [BW-2:0] fid_pix,
  input  logic [LW-1:0] vb_on_line,
  input  logic [BW-2:0] vb_on_pix,
  input  logic [LW-1:0] vb_off_line,
  input  logic [BW-2:0] vb_off_pix,
  input  logic [LW-1:0] vbi_lines,
  output logic          v_line,
  output logic [3:0]    sync_q,
  output logic          avid_q
);

  // sync_q order: 0 hsync, 1 vsync, 2 fid, 3 vblk
  localparam int          NSYNC   = 4;
  localparam logic [3:0]  RST_VAL = 4'b0100;

  logic [BW-2:0]    pix;
  logic             on_px;
  logic [NSYNC-1:0] set_hit, clr_hit;
  logic             avid_nxt;

  always_comb begin
    pix        = bcnt[BW-1:1];
    on_px      = ~bcnt[0];
    set_hit[0] = on_px && (pix == hs_on_pix);
    clr_hit[0] = on_px && (pix == hs_off_pix);
    set_hit[1] = on_px && (lif == vs_on_line) && (pix == vs_on_pix);
    clr_hit[1] = on_px && (lif == vs_off_line) && (pix == vs_off_pix);
    set_hit[2] = on_px && (line == fid_odd_line) && (pix == fid_pix);
    clr_hit[2] = on_px && (line == fid_even_line) && (pix == fid_pix);
    set_hit[3] = on_px && (lif == vb_on_line) && (pix == vb_on_pix);
    clr_hit[3] = on_px && (lif == vb_off_line) && (pix == vb_off_pix);
    v_line     = (lif < vbi_lines);
    avid_nxt   = (bcnt >= act_start) && (!v_line || avid_in_vbi);
  end

  for (genvar g = 0; g < NSYNC; g++) begin : g_edge
    logic q_r, q_nxt;

    always_comb begin
      q_nxt = q_r;
      if (set_hit[g])      q_nxt = 1'b1;
      else if (clr_hit[g]) q_nxt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= RST_VAL[g];
      else        q_r <= q_nxt;
    end

    assign sync_q[g] = q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) avid_q <= 1'b0;
    else        avid_q <= avid_nxt;
  end

endmodule

// File: rtl/vid656_datamux.sv
module vid656_datamux
  import vid656_pkg::*;
#(
  parameter int BW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          emb_mode,
  input  logic [BW-1:0] bcnt,
  input  logic [BW-1:0] act_start,
  input  logic          field2,
  input  logic          v_line,
  input  logic [7:0]    c_in,
  input  logic [7:0]    y_in,
  output logic [7:0]    dout
);

  logic [BW-1:0] sav_base;
  logic [1:0]    idx;
  logic          in_code, h_bit;
  logic [7:0]    sample, dout_nxt, dout_q;

  always_comb begin
    sav_base = act_start - BW'(4);
    in_code  = 1'b0;
    h_bit    = 1'b0;
    idx      = bcnt[1:0];
    if (bcnt < BW'(4)) begin
      in_code = 1'b1;
      h_bit   = 1'b1;
    end else if ((bcnt >= sav_base) && (bcnt < act_start)) begin
      in_code = 1'b1;
      idx     = 2'(bcnt - sav_base);
    end

    sample = bcnt[0] ? y_in : c_in;
    if (sample == 8'h00)      sample = 8'h01;
    else if (sample == 8'hFF) sample = 8'hFE;

    if (emb_mode && in_code) begin
      case (idx)
        2'd0:    dout_nxt = CODE_LEAD;
        2'd3:    dout_nxt = timing_word(field2, v_line, h_bit);
        default: dout_nxt = CODE_ZERO;
      endcase
    end else if ((bcnt >= act_start) && !v_line) begin
      dout_nxt = sample;
    end else begin
      dout_nxt = bcnt[0] ? BLANK_LUMA : BLANK_CHROMA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= 8'h00;
    else        dout_q <= dout_nxt;
  end

  assign dout = dout_q;

endmodule

// File: rtl/vid656_fmt.sv
module vid656_fmt #(
  parameter int TOT_A   = 858,
  parameter int ACT_A   = 720,
  parameter int LINES_A = 525,
  parameter int TOT_B   = 864,
  parameter int ACT_B   = 720,
  parameter int LINES_B = 625,
  localparam int MAX_TOT   = (TOT_A > TOT_B) ? TOT_A : TOT_B,
  localparam int MAX_LINES = (LINES_A > LINES_B) ? LINES_A : LINES_B,
  localparam int BW = $clog2(2 * MAX_TOT),
  localparam int PW = BW - 1,
  localparam int LW = $clog2(MAX_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          std_sel,
  input  logic          emb_mode,
  input  logic          avid_in_vbi,
  input  logic [7:0]    c_in,
  input  logic [7:0]    y_in,
  input  logic [PW-1:0] hs_on_pix,
  input  logic [PW-1:0] hs_off_pix,
  input  logic [LW-1:0] vs_on_line,
  input  logic [PW-1:0] vs_on_pix,
  input  logic [LW-1:0] vs_off_line,
  input  logic [PW-1:0] vs_off_pix,
  input  logic [LW-1:0] fid_odd_line,
  input  logic [LW-1:0] fid_even_line,
  input  logic [PW-1:0] fid_pix,
  input  logic [LW-1:0] vb_on_line,
  input  logic [PW-1:0] vb_on_pix,
  input  logic [LW-1:0] vb_off_line,
  input  logic [PW-1:0] vb_off_pix,
  input  logic [LW-1:0] vbi_lines,
  output logic [7:0]    dout,
  output logic          hsync,
  output logic          vsync,
  output logic          fid,
  output logic          vblk,
  output logic          avid
);

  logic          rst_n_int;
  logic [BW-1:0] bcnt, act_start;
  logic [LW-1:0] line, lif;
  logic          field2, v_line;
  logic [3:0]    sync_q;

  vid656_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_int)
  );

  vid656_raster #(
    .TOT_A(TOT_A), .ACT_A(ACT_A), .LINES_A(LINES_A),
    .TOT_B(TOT_B), .ACT_B(ACT_B), .LINES_B(LINES_B),
    .BW(BW), .LW(LW)
  ) u_raster (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .std_sel   (std_sel),
    .bcnt      (bcnt),
    .line      (line),
    .lif       (lif),
    .field2    (field2),
    .act_start (act_start)
  );

  vid656_syncgen #(.BW(BW), .LW(LW)) u_sync (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .bcnt          (bcnt),
    .line          (line),
    .lif           (lif),
    .act_start     (act_start),
    .avid_in_vbi   (avid_in_vbi),
    .hs_on_pix     (hs_on_pix),
    .hs_off_pix    (hs_off_pix),
    .vs_on_line    (vs_on_line),
    .vs_on_pix     (vs_on_pix),
    .vs_off_line   (vs_off_line),
    .vs_off_pix    (vs_off_pix),
    .fid_odd_line  (fid_odd_line),
    .fid_even_line (fid_even_line),
    .fid_pix       (fid_pix),
    .vb_on_line    (vb_on_line),
    .vb_on_pix     (vb_on_pix),
    .vb_off_line   (vb_off_line),
    .vb_off_pix    (vb_off_pix),
    .vbi_lines     (vbi_lines),
    .v_line        (v_line),
    .sync_q        (sync_q),
    .avid_q        (avid)
  );

  vid656_datamux #(.BW(BW)) u_mux (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .emb_mode  (emb_mode),
    .bcnt      (bcnt),
    .act_start (act_start),
    .field2    (field2),
    .v_line    (v_line),
    .c_in      (c_in),
    .y_in      (y_in),
    .dout      (dout)
  );

  assign hsync = sync_q[0];
  assign vsync = sync_q[1];
  assign fid   = sync_q[2];
  assign vblk  = sync_q[3];

endmodule

// File: rtl/vid656_fmt_chk.sv
module vid656_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       emb_mode,
  input logic [7:0] dout,
  input logic       hsync,
  input logic       vsync,
  input logic       fid,
  input logic       avid
);

  // R4
  code_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout == 8'hFF) |=> (dout == 8'h00));

  // R4
  code_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dout, 3) == 8'hFF && $past(dout, 2) == 8'h00 && $past(dout, 1) == 8'h00)
    |-> (dout[7] && dout[3:0] == {dout[5] ^ dout[4], dout[6] ^ dout[4],
                                  dout[6] ^ dout[5], dout[6] ^ dout[5] ^ dout[4]}));

  // R5
  active_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avid |-> (dout != 8'hFF && dout != 8'h00));

  // R11
  sav_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emb_mode && $rose(avid)) |-> ($past(dout[7]) && !$past(dout[4])));

  // R7
  hsync_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hsync) |=> $stable(hsync));

  // R8
  vsync_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync) |=> $stable(vsync));

  // R9
  fid_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fid) |=> $stable(fid));

endmodule

bind vid656_fmt vid656_fmt_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .emb_mode (emb_mode),
  .dout     (dout),
  .hsync    (hsync),
  .vsync    (vsync),
  .fid      (fid),
  .avid     (avid)
);

// File: tb/vid656_fmt_bench.sv
module vid656_fmt_bench;

  localparam int TA = 20, AA = 12, LA = 9;
  localparam int TB = 24, AB = 14, LB = 11;
  localparam int BW = $clog2(2 * ((TA > TB) ? TA : TB));
  localparam int PW = BW - 1;
  localparam int LW = $clog2((LA > LB) ? LA : LB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic std_sel, emb_mode, avid_in_vbi;
  logic [7:0] c_in, y_in;
  logic [PW-1:0] hs_on_pix, hs_off_pix, vs_on_pix, vs_off_pix, fid_pix, vb_on_pix, vb_off_pix;
  logic [LW-1:0] vs_on_line, vs_off_line, fid_odd_line, fid_even_line, vb_on_line, vb_off_line, vbi_lines;
  logic [7:0] dout;
  logic hsync, vsync, fid, vblk, avid;

  always #2.5 clk = ~clk;

  vid656_fmt #(.TOT_A(TA), .ACT_A(AA), .LINES_A(LA), .TOT_B(TB), .ACT_B(AB), .LINES_B(LB)) u_vid656_fmt (
    .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .emb_mode(emb_mode), .avid_in_vbi(avid_in_vbi),
    .c_in(c_in), .y_in(y_in), .hs_on_pix(hs_on_pix), .hs_off_pix(hs_off_pix),
    .vs_on_line(vs_on_line), .vs_on_pix(vs_on_pix), .vs_off_line(vs_off_line), .vs_off_pix(vs_off_pix),
    .fid_odd_line(fid_odd_line), .fid_even_line(fid_even_line), .fid_pix(fid_pix),
    .vb_on_line(vb_on_line), .vb_on_pix(vb_on_pix), .vb_off_line(vb_off_line), .vb_off_pix(vb_off_pix),
    .vbi_lines(vbi_lines), .dout(dout), .hsync(hsync), .vsync(vsync), .fid(fid), .vblk(vblk), .avid(avid)
  );

  typedef struct packed {
    logic [7:0]  d;
    logic        hs, vs, fd, vb, av;
    logic [23:0] tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int mb, ml, mstd;
  bit ehs, evs, efid, evb, sw_flag;

  task automatic chk(input logic [23:0] tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pick();
    int r = $urandom_range(0, 9);
    if (r == 0) return 8'h00;
    if (r == 1) return 8'hFF;
    return 8'($urandom_range(0, 255));
  endfunction

  task automatic model_reset();
    mb = 0; ml = 0; mstd = 0;
    ehs = 0; evs = 0; efid = 1; evb = 0; sw_flag = 0;
  endtask

  // expected outputs for the coming edge, then step the reference raster
  task automatic push_expected();
    exp_t e;
    int tot   = mstd ? TB : TA;
    int lines = mstd ? LB : LA;
    int f2    = lines / 2 + 1;
    int act   = 2 * (tot - (mstd ? AB : AA));
    int pix   = mb / 2;
    bit on    = (mb % 2) == 0;
    bit fld   = ml >= f2;
    int lif   = fld ? ml - f2 : ml;
    bit vl    = lif < int'(vbi_lines);
    bit code  = 0;
    bit hb    = 0;
    int idx   = 0;
    logic [7:0] s;
    if (on) begin
      if (pix == int'(hs_on_pix)) ehs = 1; else if (pix == int'(hs_off_pix)) ehs = 0;
      if (lif == int'(vs_on_line) && pix == int'(vs_on_pix)) evs = 1;
      else if (lif == int'(vs_off_line) && pix == int'(vs_off_pix)) evs = 0;
      if (ml == int'(fid_odd_line) && pix == int'(fid_pix)) efid = 1;
      else if (ml == int'(fid_even_line) && pix == int'(fid_pix)) efid = 0;
      if (lif == int'(vb_on_line) && pix == int'(vb_on_pix)) evb = 1;
      else if (lif == int'(vb_off_line) && pix == int'(vb_off_pix)) evb = 0;
    end
    e.hs = ehs; e.vs = evs; e.fd = efid; e.vb = evb;
    e.av = (mb >= act) && (!vl || avid_in_vbi);
    if (mb < 4) begin code = 1; hb = 1; idx = mb; end
    else if (mb >= act - 4 && mb < act) begin code = 1; idx = mb - (act - 4); end
    if (code && emb_mode) begin
      e.d = (idx == 0) ? 8'hFF : (idx == 3) ?
            {1'b1, fld, vl, hb, vl ^ hb, fld ^ hb, fld ^ vl, fld ^ vl ^ hb} : 8'h00;
      e.tag = hb ? ((ml == 0) ? "R2" : "R1") : "R4";
      if (hb && ml == 0 && sw_flag) e.tag = "R3";
    end else if (code) begin
      e.d = on ? 8'h80 : 8'h10;
      e.tag = "R6";
    end else if (mb >= act && !vl) begin
      s = on ? c_in : y_in;
      e.d = (s == 8'h00) ? 8'h01 : (s == 8'hFF) ? 8'hFE : s;
      e.tag = "R5";
    end else begin
      e.d = on ? 8'h80 : 8'h10;
      e.tag = "R5";
    end
    q.push_back(e);
    mb++;
    if (mb == 2 * tot) begin
      mb = 0;
      if (ml == lines - 1) begin
        ml = 0;
        sw_flag = (int'(std_sel) != mstd);
        mstd = int'(std_sel);
      end else begin
        ml++;
        sw_flag = 0;
      end
    end
  endtask

  task automatic compare_one();
    exp_t e = q.pop_front();
    chk(e.tag, 32'(dout), 32'(e.d));
    chk("R7", 32'(hsync), 32'(e.hs));
    chk("R8", 32'(vsync), 32'(e.vs));
    chk("R9", 32'(fid), 32'(e.fd));
    chk("R10", 32'(vblk), 32'(e.vb));
    chk("R11", 32'(avid), 32'(e.av));
  endtask

  task automatic run_bytes(input int n, input bit sel);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (q.size() > 0) compare_one();
      std_sel = sel;
      c_in = pick();
      y_in = pick();
      push_expected();
    end
  endtask

  task automatic drain();
    @(negedge clk);
    while (q.size() > 0) compare_one();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset state at the ports
    chk("R12", 32'(dout), 32'h00);
    chk("R12", 32'(hsync), 32'd0);
    chk("R12", 32'(vsync), 32'd0);
    chk("R12", 32'(fid), 32'd1);
    chk("R12", 32'(vblk), 32'd0);
    chk("R12", 32'(avid), 32'd0);
    rst_n = 1'b1;
    model_reset();
    @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    std_sel = 0; emb_mode = 1; avid_in_vbi = 0; c_in = 8'h40; y_in = 8'h50;
    hs_on_pix = 2; hs_off_pix = 6;
    vs_on_line = 1; vs_on_pix = 3; vs_off_line = 2; vs_off_pix = 3;
    fid_odd_line = 0; fid_even_line = 5; fid_pix = 0;
    vb_on_line = 0; vb_on_pix = 1; vb_off_line = 3; vb_off_pix = 1;
    vbi_lines = 2;
    // phase 1: embedded codes, mid-frame standard changes (R3)
    do_reset();
    run_bytes(50, 1'b0);
    run_bytes(450, 1'b1);
    run_bytes(600, 1'b0);
    drain();
    // phase 2: discrete syncs, wrapping hsync window, avid in blanking lines
    emb_mode = 0; avid_in_vbi = 1; std_sel = 1;
    hs_on_pix = 18; hs_off_pix = 1;
    vs_on_line = 0; vs_on_pix = 10; vs_off_line = 1; vs_off_pix = 0;
    fid_odd_line = 1; fid_even_line = 6; fid_pix = 7;
    vb_on_line = 3; vb_on_pix = 0; vb_off_line = 0; vb_off_pix = 5;
    vbi_lines = 1;
    do_reset();
    run_bytes(1000, 1'b1);
    drain();
    // phase 3: embedded codes with avid through blanking lines, 625 after first frame
    emb_mode = 1; avid_in_vbi = 1; vbi_lines = 3;
    do_reset();
    run_bytes(900, 1'b1);
    drain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule